// File: doc/BRIEF.md
# Backward Dependence Slice Extractor

When retirement halts behind a load that missed in the cache, this block finds the short chain of micro-ops in the reorder buffer that computes an address for another instance of that load. It uses only the reorder buffer's own searchable fields. The chain's members are marked in a per-entry bit vector and then streamed out in program order, so that a replay buffer can loop over them while the front end sleeps. The result code tells a surrounding policy whether to run ahead from that buffer or to fall back to conventional runahead.

A run begins with a `start_i` pulse that carries the stalled micro-op's PC. The reorder buffer is presented in program order: entry 0 is the oldest and is the stalled load itself. The block first looks for a seed, which is a different entry with the same PC. It then works through a queue of physical source registers, one per cycle. For each register it matches the destination field to find the producer, adds that producer to the chain and queues the producer's own sources. When an added micro-op is a load, the block queries the store queue, and a forwarding store joins the chain together with its sources. The reorder buffer and the store queue answers must stay stable while `busy_o` is high.

Top module: `dce_engine`

## Requirements
- R1: If no valid, non-control entry at index 1 or higher has the stalled PC, the run ends with result code 1 (no seed). Length and membership are both zero, and no fill lanes are driven.
- R2: The seed is the lowest-indexed valid, non-control entry at index 1 or higher whose PC equals `stall_pc_i`. Index 0 and control-flow entries are never seeds.
- R3: Each source register of a newly added member is queued. Each cycle one queued register is looked up against the destination fields. The lowest-indexed valid, non-control entry with that destination joins the chain, and `chain_len_o` equals the number of set bits in `chain_mask_o`.
- R4: An entry flagged as control flow is never a member, even when its destination matches a queued register.
- R5: When a newly added member is a load, `sq_req_o` is raised in the same cycle with its index. A store hit adds the returned store entry and queues that store's source registers.
- R6: A register with no producer is discarded. A register already queued in the current run is not queued again. The search list holds 16 registers, and registers pushed while it is full are discarded.
- R7: The search finishes with result code 0 (success) when the list empties, and a chain of exactly 32 members is still a success.
- R8: If a step would take the chain past 32 members, the run ends with result code 2 (too long). Length stays at 32, membership keeps the 32 members already found, and no fill lanes are driven.
- R9: After a success, member indices appear on the fill lanes in ascending order, up to 4 per cycle. Lanes fill from lane 0 without gaps, and every member appears exactly once.
- R10: `done_o` is high for exactly one cycle at the end of each run, and `busy_o` is high from the cycle after `start_i` through that cycle. A `start_i` pulse while busy has no effect.
- R11: After reset, `busy_o`, `done_o`, `result_o`, `chain_len_o`, `chain_mask_o` and all fill lanes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (taken only when idle) |
| stall_pc_i | input | PC_W | PC of the stalled load at entry 0 |
| rob_valid_i | input | DEPTH | Entry holds a micro-op |
| rob_pc_i | input | DEPTH x PC_W | PC per entry |
| rob_has_dst_i | input | DEPTH | Entry writes a destination register |
| rob_dst_i | input | DEPTH x PREG_W | Destination physical register |
| rob_src_vld_i | input | DEPTH x NSRC | Source operand present |
| rob_src_i | input | DEPTH x NSRC x PREG_W | Source physical registers |
| rob_is_ctrl_i | input | DEPTH | Entry is control flow |
| rob_is_load_i | input | DEPTH | Entry is a load |
| sq_req_o | output | 1 | Store queue query for a newly added load |
| sq_load_idx_o | output | IW | Entry index of that load |
| sq_hit_i | input | 1 | A store forwards to that load (same cycle) |
| sq_store_idx_i | input | IW | Entry index of the forwarding store |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run strobe |
| result_o | output | 2 | 0 success, 1 no seed, 2 too long |
| chain_len_o | output | LEN_W | Number of members |
| chain_mask_o | output | DEPTH | Membership, one bit per entry |
| fill_vld_o | output | LANES | Fill lane carries an index |
| fill_idx_o | output | LANES x IW | Member index per fill lane |

## Verification
On every cycle, the embedded properties check that the length never exceeds the cap, that the length agrees with the population of the membership vector, and that no control-flow entry is ever marked. They also check that the end strobe lasts a single cycle, that a failed seed search leaves an empty chain, that the lead fill lane always names a member, and that the search list never overflows its capacity. Which entries end up in the chain can only be shown by the bench's scenarios. These include choosing the oldest same-PC instance, following a store-forwarding link, dropping unproduced registers, the boundary between a 32-member success and a 33rd-member abort, and the ascending order of the streamed indices.

// File: rtl/dce_pkg.sv
package dce_pkg;
  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_NO_SEED  = 2'd1,
    RES_TOO_LONG = 2'd2
  } dce_res_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_FILL = 2'd2,
    ST_DONE = 2'd3
  } dce_st_e;
endpackage

// File: rtl/dce_prio_pick.sv
module dce_prio_pick #(
  parameter int W  = 8,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  // lowest set bit wins (oldest in program order)
  always_comb begin
    found_o = |vec_i;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/dce_reg_list.sv
module dce_reg_list #(
  parameter int RW     = 7,
  parameter int NREG   = 1 << RW,
  parameter int LDEPTH = 16,   // power of two
  parameter int NPUSH  = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      pop_i,
  input  logic [NPUSH-1:0]          push_vld_i,
  input  logic [NPUSH-1:0][RW-1:0]  push_reg_i,
  output logic                      empty_o,
  output logic [RW-1:0]             head_o
);
  localparam int PW = $clog2(LDEPTH);
  localparam int CW = $clog2(LDEPTH + 1);

  logic [LDEPTH-1:0][RW-1:0] mem_q;
  logic [NREG-1:0]           seen_q, seen_d, seen_b;
  logic [PW-1:0]             rd_q, rd_d, rd_b, wr_q, wr_d, wr_b;
  logic [CW-1:0]             cnt_q, cnt_d, cnt_b;
  logic [NPUSH-1:0]          wr_en;
  logic [NPUSH-1:0][PW-1:0]  wr_slot;
  logic                      pop_ok;
  int                        nacc, room;

  always_comb begin
    seen_b = clr_i ? '0 : seen_q;
    cnt_b  = clr_i ? '0 : cnt_q;
    rd_b   = clr_i ? '0 : rd_q;
    wr_b   = clr_i ? '0 : wr_q;
    pop_ok = pop_i && !clr_i && (cnt_q != '0);
    room   = LDEPTH - int'(cnt_b) + (pop_ok ? 1 : 0);
    nacc   = 0;
    seen_d = seen_b;
    wr_en  = '0;
    wr_slot = '0;
    // in-order acceptance; duplicates and pushes past capacity are dropped
    for (int p = 0; p < NPUSH; p++) begin
      if (push_vld_i[p] && !seen_d[push_reg_i[p]] && (nacc < room)) begin
        wr_en[p]   = 1'b1;
        wr_slot[p] = wr_b + PW'(nacc);
        seen_d[push_reg_i[p]] = 1'b1;
        nacc = nacc + 1;
      end
    end
    rd_d  = rd_b + PW'(pop_ok ? 1 : 0);
    wr_d  = wr_b + PW'(nacc);
    cnt_d = CW'(int'(cnt_b) - (pop_ok ? 1 : 0) + nacc);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      cnt_q  <= '0;
    end else begin
      seen_q <= seen_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < NPUSH; p++) begin
      if (wr_en[p]) mem_q[wr_slot[p]] <= push_reg_i[p];
    end
  end

  assign empty_o = (cnt_q == '0);
  assign head_o  = mem_q[rd_q];

  p_list_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LDEPTH));
endmodule

// File: rtl/dce_fill_stream.sv
module dce_fill_stream #(
  parameter int DEPTH = 192,
  parameter int IW    = $clog2(DEPTH),
  parameter int LANES = 4
) (
  input  logic [DEPTH-1:0]           rem_i,
  output logic [LANES-1:0]           lane_vld_o,
  output logic [LANES-1:0][IW-1:0]   lane_idx_o,
  output logic [DEPTH-1:0]           rem_next_o
);
  logic [LANES:0][DEPTH-1:0] stage;

  assign stage[0] = rem_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dce_prio_pick #(.W(DEPTH), .IW(IW)) u_pick (
      .vec_i   (stage[g]),
      .found_o (lane_vld_o[g]),
      .idx_o   (lane_idx_o[g])
    );
    assign stage[g+1] = stage[g] &
      ~(lane_vld_o[g] ? (DEPTH'(1) << lane_idx_o[g]) : DEPTH'(0));
  end

  assign rem_next_o = stage[LANES];
endmodule

// File: rtl/dce_engine.sv
module dce_engine
  import dce_pkg::*;
#(
  parameter int DEPTH      = 192,
  parameter int PC_W       = 16,
  parameter int PREG_W     = 7,
  parameter int NSRC       = 2,
  parameter int MAX_LEN    = 32,
  parameter int LIST_DEPTH = 16,
  parameter int LANES      = 4,
  localparam int IW        = $clog2(DEPTH),
  localparam int LEN_W     = $clog2(MAX_LEN + 1)
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 start_i,
  input  logic [PC_W-1:0]                      stall_pc_i,
  input  logic [DEPTH-1:0]                     rob_valid_i,
  input  logic [DEPTH-1:0][PC_W-1:0]           rob_pc_i,
  input  logic [DEPTH-1:0]                     rob_has_dst_i,
  input  logic [DEPTH-1:0][PREG_W-1:0]         rob_dst_i,
  input  logic [DEPTH-1:0][NSRC-1:0]           rob_src_vld_i,
  input  logic [DEPTH-1:0][NSRC-1:0][PREG_W-1:0] rob_src_i,
  input  logic [DEPTH-1:0]                     rob_is_ctrl_i,
  input  logic [DEPTH-1:0]                     rob_is_load_i,
  output logic                                 sq_req_o,
  output logic [IW-1:0]                        sq_load_idx_o,
  input  logic                                 sq_hit_i,
  input  logic [IW-1:0]                        sq_store_idx_i,
  output logic                                 busy_o,
  output logic                                 done_o,
  output logic [1:0]                           result_o,
  output logic [LEN_W-1:0]                     chain_len_o,
  output logic [DEPTH-1:0]                     chain_mask_o,
  output logic [LANES-1:0]                     fill_vld_o,
  output logic [LANES-1:0][IW-1:0]             fill_idx_o
);
  localparam int NPUSH = 2 * NSRC;

  dce_st_e                   st_q, st_d;
  dce_res_e                  res_q, res_d;
  logic [DEPTH-1:0]          mask_q, mask_d, rem_q, rem_d, rem_nxt;
  logic [LEN_W-1:0]          len_q, len_d;

  logic [DEPTH-1:0]          seed_hit, prod_hit, cand_vec, new_bits;
  logic                      cand_found, cand_new, st_ok, st_new, over;
  logic [IW-1:0]             cand_idx;
  logic                      seeding, walking;
  logic                      list_empty;
  logic [PREG_W-1:0]         list_head;
  logic [NPUSH-1:0]          push_vld;
  logic [NPUSH-1:0][PREG_W-1:0] push_reg;
  logic [LANES-1:0]          lane_vld;
  logic [LANES-1:0][IW-1:0]  lane_idx;
  int                        add_n;

  // associative match lines
  for (genvar g = 0; g < DEPTH; g++) begin : g_cam
    assign seed_hit[g] = rob_valid_i[g] && !rob_is_ctrl_i[g] &&
                         (rob_pc_i[g] == stall_pc_i) && (g != 0);
    assign prod_hit[g] = rob_valid_i[g] && rob_has_dst_i[g] && !rob_is_ctrl_i[g] &&
                         (rob_dst_i[g] == list_head);
  end

  assign seeding  = (st_q == ST_IDLE) && start_i;
  assign walking  = (st_q == ST_WALK) && !list_empty;
  assign cand_vec = seeding ? seed_hit : prod_hit;

  dce_prio_pick #(.W(DEPTH), .IW(IW)) u_cand (
    .vec_i   (cand_vec),
    .found_o (cand_found),
    .idx_o   (cand_idx)
  );

  assign cand_new      = (seeding || walking) && cand_found &&
                         (seeding || !mask_q[cand_idx]);
  assign sq_req_o      = cand_new && rob_is_load_i[cand_idx];
  assign sq_load_idx_o = cand_idx;
  assign st_ok         = sq_req_o && sq_hit_i && (int'(sq_store_idx_i) < DEPTH) &&
                         (sq_store_idx_i != cand_idx);
  assign st_new        = st_ok && (seeding || !mask_q[sq_store_idx_i]);
  assign add_n         = (cand_new ? 1 : 0) + (st_new ? 1 : 0);
  assign over          = walking && ((int'(len_q) + add_n) > MAX_LEN);
  assign new_bits      = (cand_new ? (DEPTH'(1) << cand_idx)       : DEPTH'(0)) |
                         (st_new   ? (DEPTH'(1) << sq_store_idx_i) : DEPTH'(0));

  for (genvar s = 0; s < NSRC; s++) begin : g_push
    assign push_vld[s]        = cand_new && !over && rob_src_vld_i[cand_idx][s];
    assign push_reg[s]        = rob_src_i[cand_idx][s];
    assign push_vld[NSRC + s] = st_new && !over && rob_src_vld_i[sq_store_idx_i][s];
    assign push_reg[NSRC + s] = rob_src_i[sq_store_idx_i][s];
  end

  dce_reg_list #(.RW(PREG_W), .LDEPTH(LIST_DEPTH), .NPUSH(NPUSH)) u_list (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (seeding),
    .pop_i      (walking),
    .push_vld_i (push_vld),
    .push_reg_i (push_reg),
    .empty_o    (list_empty),
    .head_o     (list_head)
  );

  dce_fill_stream #(.DEPTH(DEPTH), .IW(IW), .LANES(LANES)) u_fill (
    .rem_i      (rem_q),
    .lane_vld_o (lane_vld),
    .lane_idx_o (lane_idx),
    .rem_next_o (rem_nxt)
  );

  always_comb begin
    st_d   = st_q;
    res_d  = res_q;
    mask_d = mask_q;
    rem_d  = rem_q;
    len_d  = len_q;
    case (st_q)
      ST_IDLE: if (start_i) begin
        if (cand_found) begin
          st_d   = ST_WALK;
          mask_d = new_bits;
          len_d  = LEN_W'(add_n);
          res_d  = RES_OK;
        end else begin
          st_d   = ST_DONE;
          mask_d = '0;
          len_d  = '0;
          res_d  = RES_NO_SEED;
        end
      end
      ST_WALK: begin
        if (list_empty) begin
          st_d  = ST_FILL;
          rem_d = mask_q;
        end else if (over) begin
          st_d  = ST_DONE;
          res_d = RES_TOO_LONG;
        end else begin
          mask_d = mask_q | new_bits;
          len_d  = LEN_W'(int'(len_q) + add_n);
        end
      end
      ST_FILL: begin
        rem_d = rem_nxt;
        if (rem_nxt == '0) st_d = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      res_q  <= RES_OK;
      mask_q <= '0;
      rem_q  <= '0;
      len_q  <= '0;
    end else begin
      st_q   <= st_d;
      res_q  <= res_d;
      mask_q <= mask_d;
      rem_q  <= rem_d;
      len_q  <= len_d;
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_DONE);
  assign result_o     = res_q;
  assign chain_len_o  = len_q;
  assign chain_mask_o = mask_q;
  assign fill_vld_o   = lane_vld & {LANES{st_q == ST_FILL}};
  assign fill_idx_o   = lane_idx;

  p_len_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(chain_len_o) <= MAX_LEN);

  p_len_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chain_mask_o) == int'(chain_len_o));

  p_ctrl_excluded_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ((chain_mask_o & rob_is_ctrl_i) == '0));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_no_seed_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (result_o == RES_NO_SEED)) |-> (chain_len_o == '0));

  p_fill_member_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_vld_o[0] |-> chain_mask_o[fill_idx_o[0]]);
endmodule

// File: tb/dce_engine_tb.sv
module dce_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 192;
  localparam int PC_W   = 16;
  localparam int PREG_W = 7;
  localparam int NSRC   = 2;
  localparam int LANES  = 4;
  localparam int IW     = $clog2(DEPTH);
  localparam int LEN_W  = $clog2(33);
  localparam logic [15:0] PC_HOT = 16'h00A0;

  typedef struct packed {
    logic [1:0]  sc;
    logic [7:0]  idx;
    logic [15:0] pc;
    logic        hd;
    logic [6:0]  dst;
    logic        v0;
    logic [6:0]  s0;
    logic        v1;
    logic [6:0]  s1;
    logic        ct;
    logic        ld;
    logic        mem;
  } op_t;

  localparam int NOPS = 19;
  localparam int NSC  = 3;
  // scenario 0: chain with store link; 1: no seed; 2: oldest seed
  localparam op_t OPS [NOPS] = '{
    '{2'd0, 8'd0,  16'h00A0, 1'b1, 7'd2,  1'b1, 7'd1,  1'b0, 7'd0,  1'b0, 1'b1, 1'b0},
    '{2'd0, 8'd1,  16'h00D0, 1'b1, 7'd4,  1'b1, 7'd3,  1'b0, 7'd0,  1'b0, 1'b1, 1'b1},
    '{2'd0, 8'd2,  16'h0011, 1'b1, 7'd9,  1'b1, 7'd4,  1'b1, 7'd5,  1'b0, 1'b0, 1'b1},
    '{2'd0, 8'd3,  16'h0012, 1'b1, 7'd6,  1'b1, 7'd9,  1'b1, 7'd1,  1'b0, 1'b0, 1'b1},
    '{2'd0, 8'd4,  16'h0013, 1'b1, 7'd7,  1'b1, 7'd6,  1'b0, 7'd0,  1'b0, 1'b0, 1'b1},
    '{2'd0, 8'd6,  16'h0014, 1'b1, 7'd11, 1'b1, 7'd6,  1'b0, 7'd0,  1'b0, 1'b0, 1'b1},
    '{2'd0, 8'd7,  16'h0015, 1'b1, 7'd5,  1'b0, 7'd0,  1'b0, 7'd0,  1'b1, 1'b0, 1'b0},
    '{2'd0, 8'd8,  16'h0016, 1'b1, 7'd30, 1'b1, 7'd1,  1'b0, 7'd0,  1'b0, 1'b0, 1'b0},
    '{2'd0, 8'd9,  16'h0017, 1'b0, 7'd0,  1'b1, 7'd11, 1'b1, 7'd12, 1'b0, 1'b0, 1'b1},
    '{2'd0, 8'd10, 16'h00A0, 1'b1, 7'd20, 1'b1, 7'd7,  1'b0, 7'd0,  1'b0, 1'b1, 1'b1},
    '{2'd0, 8'd12, 16'h00A0, 1'b1, 7'd21, 1'b1, 7'd7,  1'b0, 7'd0,  1'b0, 1'b1, 1'b0},
    '{2'd1, 8'd0,  16'h00A0, 1'b1, 7'd2,  1'b1, 7'd1,  1'b0, 7'd0,  1'b0, 1'b1, 1'b0},
    '{2'd1, 8'd3,  16'h00A0, 1'b0, 7'd0,  1'b0, 7'd0,  1'b0, 7'd0,  1'b1, 1'b0, 1'b0},
    '{2'd1, 8'd5,  16'h00B0, 1'b1, 7'd8,  1'b1, 7'd2,  1'b0, 7'd0,  1'b0, 1'b0, 1'b0},
    '{2'd2, 8'd0,  16'h00A0, 1'b1, 7'd2,  1'b1, 7'd1,  1'b0, 7'd0,  1'b0, 1'b1, 1'b0},
    '{2'd2, 8'd3,  16'h0031, 1'b1, 7'd41, 1'b0, 7'd0,  1'b0, 7'd0,  1'b0, 1'b0, 1'b1},
    '{2'd2, 8'd5,  16'h00A0, 1'b1, 7'd40, 1'b1, 7'd41, 1'b0, 7'd0,  1'b0, 1'b1, 1'b1},
    '{2'd2, 8'd8,  16'h0032, 1'b1, 7'd43, 1'b0, 7'd0,  1'b0, 7'd0,  1'b0, 1'b0, 1'b0},
    '{2'd2, 8'd9,  16'h00A0, 1'b1, 7'd42, 1'b1, 7'd43, 1'b0, 7'd0,  1'b0, 1'b1, 1'b0}
  };
  localparam logic [1:0] EXP_RES [NSC] = '{2'd0, 2'd1, 2'd0};

  logic clk, rst_n, start;
  logic [PC_W-1:0] stall_pc;
  logic [DEPTH-1:0] rob_valid, rob_has_dst, rob_ctrl, rob_load;
  logic [DEPTH-1:0][PC_W-1:0] rob_pc;
  logic [DEPTH-1:0][PREG_W-1:0] rob_dst;
  logic [DEPTH-1:0][NSRC-1:0] rob_src_vld;
  logic [DEPTH-1:0][NSRC-1:0][PREG_W-1:0] rob_src;
  logic sq_req, sq_hit;
  logic [IW-1:0] sq_load_idx, sq_store_idx;
  logic busy, done;
  logic [1:0] result;
  logic [LEN_W-1:0] chain_len;
  logic [DEPTH-1:0] chain_mask;
  logic [LANES-1:0] fill_vld;
  logic [LANES-1:0][IW-1:0] fill_idx;

  logic sq_en;
  logic [IW-1:0] sq_ld, sq_st;

  int total, bad;

  dce_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stall_pc_i(stall_pc),
    .rob_valid_i(rob_valid), .rob_pc_i(rob_pc), .rob_has_dst_i(rob_has_dst),
    .rob_dst_i(rob_dst), .rob_src_vld_i(rob_src_vld), .rob_src_i(rob_src),
    .rob_is_ctrl_i(rob_ctrl), .rob_is_load_i(rob_load),
    .sq_req_o(sq_req), .sq_load_idx_o(sq_load_idx), .sq_hit_i(sq_hit),
    .sq_store_idx_i(sq_store_idx), .busy_o(busy), .done_o(done),
    .result_o(result), .chain_len_o(chain_len), .chain_mask_o(chain_mask),
    .fill_vld_o(fill_vld), .fill_idx_o(fill_idx)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // store queue model: one forwarding pair per scenario
  always_comb begin
    sq_hit       = sq_en && sq_req && (sq_load_idx == sq_ld);
    sq_store_idx = sq_st;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_rob();
    rob_valid = '0; rob_has_dst = '0; rob_ctrl = '0; rob_load = '0;
    rob_pc = '0; rob_dst = '0; rob_src_vld = '0; rob_src = '0;
    sq_en = 1'b0; sq_ld = '0; sq_st = '0;
  endtask

  task automatic put_op(input int i, input logic [15:0] pc, input logic hd,
                        input logic [6:0] dst, input logic v0, input logic [6:0] s0,
                        input logic v1, input logic [6:0] s1, input logic ct, input logic ld);
    rob_valid[i] = 1'b1; rob_pc[i] = pc; rob_has_dst[i] = hd; rob_dst[i] = dst;
    rob_src_vld[i][0] = v0; rob_src[i][0] = s0;
    rob_src_vld[i][1] = v1; rob_src[i][1] = s1;
    rob_ctrl[i] = ct; rob_load[i] = ld;
  endtask

  task automatic run_case(input string req, input logic [1:0] eres,
                          input logic [DEPTH-1:0] emask, input bit poke);
    int seen [64];
    int nseen, cyc, k, exp_cnt;
    bit packed_ok, order_ok;
    nseen = 0; cyc = 0; packed_ok = 1'b1; order_ok = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    forever begin
      if (poke && cyc == 5) begin start = 1'b1; stall_pc = 16'h0BEE; end
      else if (poke && cyc == 6) begin start = 1'b0; stall_pc = PC_HOT; end
      for (int g = 0; g < LANES; g++) begin
        if (fill_vld[g]) begin
          if (g > 0 && !fill_vld[g-1]) packed_ok = 1'b0;
          if (nseen < 64) seen[nseen] = int'(fill_idx[g]);
          nseen++;
        end
      end
      if (done || cyc > 3000) break;
      if (!busy) chk(1'b0, "R10", "busy dropped before done", 0, 1);
      cyc++;
      @(negedge clk);
    end
    chk(done, "R10", "done reached", done, 1);
    chk(result == eres, req, "result code", result, eres);
    chk(chain_mask == emask, req, "membership", chain_mask, emask);
    exp_cnt = $countones(emask);
    chk(int'(chain_len) == exp_cnt, req, "chain length", chain_len, exp_cnt);
    if (eres != 2'd0) exp_cnt = 0;
    chk(nseen == exp_cnt, "R9", "fill count", nseen, exp_cnt);
    k = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (emask[i] && eres == 2'd0 && k < nseen && k < 64) begin
        if (seen[k] != i) order_ok = 1'b0;
        k++;
      end
    end
    chk(order_ok && packed_ok, "R9", "fill order and packing", {order_ok, packed_ok}, 2'b11);
    @(negedge clk);
    chk(!done && !busy, "R10", "single-cycle done", {done, busy}, 2'b00);
  endtask

  initial begin
    logic [DEPTH-1:0] emask;
    total = 0; bad = 0;
    start = 1'b0; stall_pc = PC_HOT;
    clear_rob();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done, "R11", "busy/done after reset", {busy, done}, 0);
    chk(result == 2'd0, "R11", "result after reset", result, 0);
    chk(chain_len == '0 && chain_mask == '0, "R11", "chain after reset", chain_len, 0);
    chk(fill_vld == '0, "R11", "fill lanes after reset", fill_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table-driven: R3/R4/R5/R6 (sc0), R1/R2 ctrl seed (sc1), R2 oldest (sc2)
    for (int sc = 0; sc < NSC; sc++) begin
      clear_rob();
      emask = '0;
      for (int e = 0; e < NOPS; e++) begin
        if (int'(OPS[e].sc) == sc) begin
          put_op(int'(OPS[e].idx), OPS[e].pc, OPS[e].hd, OPS[e].dst, OPS[e].v0,
                 OPS[e].s0, OPS[e].v1, OPS[e].s1, OPS[e].ct, OPS[e].ld);
          if (OPS[e].mem) emask[OPS[e].idx] = 1'b1;
        end
      end
      if (sc == 0) begin sq_en = 1'b1; sq_ld = IW'(1); sq_st = IW'(9); end
      if (sc == 0)      run_case("R3_R4_R5_R6", EXP_RES[sc], emask, 1'b0);
      else if (sc == 1) run_case("R1_R2", EXP_RES[sc], emask, 1'b0);
      else              run_case("R2", EXP_RES[sc], emask, 1'b0);
    end

    // R7: exactly 32 members is still a success
    clear_rob();
    put_op(0, PC_HOT, 1'b1, 7'd2, 1'b1, 7'd1, 1'b0, 7'd0, 1'b0, 1'b1);
    put_op(1, PC_HOT, 1'b1, 7'd100, 1'b1, 7'd50, 1'b0, 7'd0, 1'b0, 1'b1);
    for (int i = 2; i <= 32; i++)
      put_op(i, 16'h0200, 1'b1, 7'(48 + i), 1'b1, 7'(49 + i), 1'b0, 7'd0, 1'b0, 1'b0);
    emask = '0;
    for (int i = 1; i <= 32; i++) emask[i] = 1'b1;
    run_case("R7", 2'd0, emask, 1'b0);

    // R8: a 33rd member aborts; R10: mid-run start is ignored
    for (int i = 33; i <= 40; i++)
      put_op(i, 16'h0200, 1'b1, 7'(48 + i), 1'b1, 7'(49 + i), 1'b0, 7'd0, 1'b0, 1'b0);
    run_case("R8_R10", 2'd2, emask, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule